// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is the digital behaviour of a small three-wire serial EEPROM, built so that it can be synthesised into a chip or an emulation target. A host raises the chip select and then clocks in a frame on the serial data input, one bit per shift-clock rising edge. It reads back data or status on a serial output that has its own drive enable. The shift clock, chip select and data input are slow compared to the system clock. They are synchronised to it, and every action of the block follows a shift-clock rising edge seen in the system clock domain.

A static width input selects one of two organisations. In word mode the array is read and written as 16-bit words. In byte mode the same storage is read and written as 8-bit bytes, and each word is split into two bytes. The block supports the following instructions:

- single and streaming reads
- word or byte programming
- word or byte erase
- whole-array erase
- whole-array fill
- a write-enable latch, with instructions to set it and to clear it

Programming is self-timed. It lasts a configurable number of system clocks. If the host deselects the block and then selects it again while programming is still running, the block reports ready/busy status on the serial output. The storage is a register array. It resets to all ones, the erased state.

Top module: `mw_eeprom`

## Requirements
- R1: A frame starts at the first 1 sampled on a shift-clock rising edge while chip select is high; 0 bits before it are ignored. Then follow a 2-bit opcode and an address field, all MSB first. The address field is 8 bits in byte mode and 7 bits in word mode. Only the low 7 bits (byte mode) or 6 bits (word mode) select a location, and the upper field bit is clocked but ignored.
- R2: Opcode 10 is a read. At the shift-clock rising edge that samples the last address bit, the output drives a single 0. Each following rising edge presents the next data bit, MSB first. In byte mode an even byte address selects bits 7:0 of word address/2 and an odd one selects bits 15:8. After reset every location reads all ones.
- R3: While chip select stays high after a read word, the address increments and the next word follows immediately with no extra 0 bit. The address wraps from the last location to location 0.
- R4: The write-enable latch is clear after reset. While it is clear, opcodes 01 and 11 and the whole-array erase and fill instructions change no location and start no programming cycle.
- R5: Opcode 00 takes the two first-clocked address-field bits as a sub-command: 11 sets the write-enable latch, 00 clears it, 10 is whole-array erase and 01 is whole-array fill. Reads work whatever the state of the latch.
- R6: Opcode 01 followed by 16 data bits (word mode) or 8 data bits (byte mode) stores that data at the address. No erase is needed first.
- R7: Opcode 11 sets every bit of the addressed word (or byte) to 1. Whole-array erase sets every bit of the array to 1.
- R8: Whole-array fill, followed by a data field, writes that pattern to every word. In byte mode the byte is written to both halves of each word.
- R9: A programming cycle starts after the last data bit (write, fill) or the last address bit (erase, whole erase) and lasts PROG_CYCLES system clocks. If chip select is lowered and raised while the cycle runs, the output drives 0 while busy and 1 once done, until chip select falls.
- R10: If chip select is raised only after the programming cycle has ended, the output stays undriven.
- R11: A frame clocked in while a programming cycle runs is ignored, and so is anything clocked in during status display.
- R12: The output drive enable is low whenever chip select is low, and also while no read data or status is being presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| org_wide | input | 1 | 1 = 16-bit word mode, 0 = 8-bit byte mode; changed only while chip select is low |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Shift clock from the host |
| di | input | 1 | Serial data input |
| dout | output | 1 | Serial data output value |
| dout_en | output | 1 | Drive enable for dout; low means high impedance |

## Verification
The hardest case to reach is the ready/busy handshake. The status appears only when chip select goes low and then high inside the programming window, and it must not appear when the host re-selects after that window. The stimulus finishes a program frame, toggles chip select at once and then polls the output. It measures the clocks from the last data edge to the ready indication. Separately, it re-selects long after completion and checks that the output stays undriven. A second frame is also clocked in during the status phase, to show that it is dropped.

// File: rtl/mw_pkg.sv
// Shared types and encodings for the three-wire serial EEPROM model.
package mw_pkg;

    // Front-end sequencing states.
    typedef enum logic [2:0] {
        FE_OFF,    // chip select low
        FE_WAIT,   // selected, waiting for the start bit
        FE_OPC,    // shifting the 2-bit opcode
        FE_ADDR,   // shifting the address field
        FE_DATA,   // shifting write/fill data
        FE_READ,   // streaming read data
        FE_STAT,   // showing ready/busy
        FE_HOLD    // frame done, ignore bits until deselect
    } fe_state_t;

    // Kinds of self-timed array operations.
    typedef enum logic [1:0] {
        PG_WRITE,
        PG_ERASE,
        PG_ERAL,
        PG_WRAL
    } pg_kind_t;

    localparam logic [1:0] OPC_EXT   = 2'b00;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_ERASE = 2'b11;

    localparam logic [1:0] SUB_LOCK  = 2'b00;
    localparam logic [1:0] SUB_FILL  = 2'b01;
    localparam logic [1:0] SUB_CLEAR = 2'b10;
    localparam logic [1:0] SUB_OPEN  = 2'b11;

endpackage

// File: rtl/mw_pin_sync.sv
// Synchronises the slow host pins into the system clock domain and detects
// shift-clock rising edges. Assumes sk and di are held stable for several
// system clocks around each sk edge, so both see the same delay.
module mw_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic cs_s,
    output logic sk_rise,
    output logic di_s
);
    logic cs_m, sk_m, di_m;
    logic sk_q, sk_d;

    // Two-stage capture of each pin plus one delayed copy of sk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_m <= 1'b0; cs_s <= 1'b0;
            sk_m <= 1'b0; sk_q <= 1'b0; sk_d <= 1'b0;
            di_m <= 1'b0; di_s <= 1'b0;
        end else begin
            cs_m <= cs;   cs_s <= cs_m;
            sk_m <= sk;   sk_q <= sk_m;  sk_d <= sk_q;
            di_m <= di;   di_s <= di_m;
        end
    end

    assign sk_rise = sk_q & ~sk_d;

endmodule

// File: rtl/mw_prog_timer.sv
// Self-timed programming interval. A start pulse loads the counter, and busy
// stays high for exactly PROG_CYCLES system clocks. Assumes no start while
// busy, which the front end guarantees.
module mw_prog_timer #(
    parameter int PROG_CYCLES = 120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);

    logic [CNT_W-1:0] left_q;

    // Load on start, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            left_q <= '0;
        else if (start)
            left_q <= CNT_W'(PROG_CYCLES);
        else if (left_q != '0)
            left_q <= left_q - 1'b1;
    end

    assign busy = (left_q != '0);

endmodule

// File: rtl/mw_array.sv
// Register storage of 2**MEM_AW 16-bit words with one combinational read port
// and one program port. In byte mode a unit address selects a byte:
// an even address is the low half of word unit/2 and an odd one the high half.
// Reset fills the array with ones (erased state).
module mw_array import mw_pkg::*; #(
    parameter int MEM_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  pg_kind_t          kind,
    input  logic              wide,
    input  logic [MEM_AW:0]   unit,
    input  logic [15:0]       data,
    input  logic [MEM_AW-1:0] rd_idx,
    output logic [15:0]       rd_word
);
    localparam int DEPTH = 1 << MEM_AW;

    logic [15:0]       mem_q [DEPTH];
    logic [MEM_AW-1:0] w_idx;
    logic              bsel;
    logic [15:0]       val;
    logic [15:0]       fill;

    // Decode the target word, the byte half and the value to store.
    always_comb begin
        w_idx = wide ? unit[MEM_AW-1:0] : unit[MEM_AW:1];
        bsel  = ~wide & unit[0];
        val   = (kind == PG_ERASE) ? 16'hFFFF : data;
        fill  = wide ? data : {data[7:0], data[7:0]};
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        // Update one word when a program operation targets it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[g] <= 16'hFFFF;
            end else if (go) begin
                case (kind)
                    PG_WRITE, PG_ERASE: begin
                        if (w_idx == MEM_AW'(g)) begin
                            if (wide)      mem_q[g]       <= val;
                            else if (bsel) mem_q[g][15:8] <= val[7:0];
                            else           mem_q[g][7:0]  <= val[7:0];
                        end
                    end
                    PG_ERAL: mem_q[g] <= 16'hFFFF;
                    PG_WRAL: mem_q[g] <= fill;
                    default: ;
                endcase
            end
        end
    end

    assign rd_word = mem_q[rd_idx];

endmodule

// File: rtl/mw_frontend.sv
// Serial protocol engine: start-bit search, opcode/address/data shifting,
// instruction decode, the write-enable latch, read streaming with prefetch,
// and ready/busy display. Acts only on synchronised sk rising edges.
// Assumes FIELD_W >= MEM_AW + 1 and FIELD_W >= 3.
module mw_frontend import mw_pkg::*; #(
    parameter int FIELD_W = 8,
    parameter int MEM_AW  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              sk_rise,
    input  logic              di_s,
    input  logic              wide,
    input  logic              busy,
    input  logic [15:0]       rd_word,
    output logic [MEM_AW-1:0] rd_idx,
    output logic              prog_go,
    output pg_kind_t          prog_kind,
    output logic [MEM_AW:0]   prog_unit,
    output logic [15:0]       prog_data,
    output logic              wren,
    output logic              dout,
    output logic              dout_en
);
    localparam int UNIT_W = MEM_AW + 1;
    localparam int CW     = $clog2((FIELD_W > 16 ? FIELD_W : 16) + 1);

    fe_state_t          state_q;
    logic [1:0]         opc_q;
    logic [FIELD_W-1:0] addr_q;
    logic [15:0]        dat_q;
    logic [15:0]        sh_q;
    logic [CW-1:0]      cnt_q;
    logic [UNIT_W-1:0]  rptr_q;

    logic [FIELD_W-1:0] addr_nx;
    logic [15:0]        dat_nx;
    logic [UNIT_W-1:0]  unit_nx;
    logic [UNIT_W-1:0]  rptr_inc;
    logic [UNIT_W-1:0]  rd_unit;
    logic [1:0]         sub_nx;
    logic [15:0]        load_val;
    logic [CW-1:0]      fld_last;
    logic [CW-1:0]      word_last;

    // Next shift values, unit address, prefetch address and field limits.
    always_comb begin
        addr_nx   = {addr_q[FIELD_W-2:0], di_s};
        dat_nx    = {dat_q[14:0], di_s};
        unit_nx   = wide ? {1'b0, addr_nx[MEM_AW-1:0]} : addr_nx[UNIT_W-1:0];
        sub_nx    = wide ? addr_nx[FIELD_W-2 -: 2] : addr_nx[FIELD_W-1 -: 2];
        rptr_inc  = wide ? {1'b0, rptr_q[MEM_AW-1:0] + 1'b1} : rptr_q + 1'b1;
        rd_unit   = (state_q == FE_READ) ? rptr_inc : unit_nx;
        rd_idx    = wide ? rd_unit[MEM_AW-1:0] : rd_unit[UNIT_W-1:1];
        load_val  = wide ? rd_word
                         : {(rd_unit[0] ? rd_word[15:8] : rd_word[7:0]), 8'h00};
        fld_last  = wide ? CW'(FIELD_W - 2) : CW'(FIELD_W - 1);
        word_last = wide ? CW'(15) : CW'(7);
    end

    // Protocol sequencer, latch and output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= FE_OFF;
            opc_q     <= '0;
            addr_q    <= '0;
            dat_q     <= '0;
            sh_q      <= '0;
            cnt_q     <= '0;
            rptr_q    <= '0;
            wren      <= 1'b0;
            dout      <= 1'b0;
            dout_en   <= 1'b0;
            prog_go   <= 1'b0;
            prog_kind <= PG_WRITE;
            prog_unit <= '0;
            prog_data <= '0;
        end else begin
            prog_go <= 1'b0;
            if (!cs_s) begin
                state_q <= FE_OFF;
                dout    <= 1'b0;
                dout_en <= 1'b0;
            end else begin
                case (state_q)
                    FE_OFF: state_q <= busy ? FE_STAT : FE_WAIT;
                    FE_STAT: begin
                        dout_en <= 1'b1;
                        dout    <= ~busy;
                    end
                    FE_WAIT: begin
                        if (sk_rise && di_s) begin
                            state_q <= FE_OPC;
                            cnt_q   <= '0;
                        end
                    end
                    FE_OPC: begin
                        if (sk_rise) begin
                            opc_q <= {opc_q[0], di_s};
                            if (cnt_q == CW'(1)) begin
                                state_q <= FE_ADDR;
                                cnt_q   <= '0;
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end
                    end
                    FE_ADDR: begin
                        if (sk_rise) begin
                            addr_q <= addr_nx;
                            cnt_q  <= cnt_q + 1'b1;
                            if (cnt_q == fld_last) begin
                                cnt_q     <= '0;
                                prog_unit <= unit_nx;
                                state_q   <= FE_HOLD;
                                case (opc_q)
                                    OPC_READ: begin
                                        state_q <= FE_READ;
                                        rptr_q  <= unit_nx;
                                        sh_q    <= load_val;
                                        dout    <= 1'b0;
                                        dout_en <= 1'b1;
                                    end
                                    OPC_WRITE: state_q <= FE_DATA;
                                    OPC_ERASE: begin
                                        prog_go   <= wren;
                                        prog_kind <= PG_ERASE;
                                    end
                                    default: begin
                                        case (sub_nx)
                                            SUB_OPEN:  wren <= 1'b1;
                                            SUB_LOCK:  wren <= 1'b0;
                                            SUB_FILL:  state_q <= FE_DATA;
                                            default: begin
                                                prog_go   <= wren;
                                                prog_kind <= PG_ERAL;
                                            end
                                        endcase
                                    end
                                endcase
                            end
                        end
                    end
                    FE_DATA: begin
                        if (sk_rise) begin
                            dat_q <= dat_nx;
                            cnt_q <= cnt_q + 1'b1;
                            if (cnt_q == word_last) begin
                                prog_go   <= wren;
                                prog_kind <= (opc_q == OPC_WRITE) ? PG_WRITE : PG_WRAL;
                                prog_data <= dat_nx;
                                state_q   <= FE_HOLD;
                            end
                        end
                    end
                    FE_READ: begin
                        if (sk_rise) begin
                            dout <= sh_q[15];
                            sh_q <= {sh_q[14:0], 1'b0};
                            if (cnt_q == word_last) begin
                                cnt_q  <= '0;
                                rptr_q <= rptr_inc;
                                sh_q   <= load_val;
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/mw_eeprom.sv
// Top level of the three-wire serial EEPROM model: pin synchroniser,
// protocol front end, program timer and register array.
// Assumes the host shift clock is several times slower than clk.
module mw_eeprom #(
    parameter int FIELD_W     = 8,
    parameter int MEM_AW      = 6,
    parameter int PROG_CYCLES = 120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic org_wide,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic dout,
    output logic dout_en
);
    import mw_pkg::*;

    logic              cs_s, sk_rise, di_s;
    logic              busy, wren, prog_go;
    pg_kind_t          prog_kind;
    logic [MEM_AW:0]   prog_unit;
    logic [15:0]       prog_data;
    logic [MEM_AW-1:0] rd_idx;
    logic [15:0]       rd_word;

    mw_pin_sync u_sync (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
        .cs_s(cs_s), .sk_rise(sk_rise), .di_s(di_s)
    );

    mw_frontend #(.FIELD_W(FIELD_W), .MEM_AW(MEM_AW)) u_fe (
        .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sk_rise(sk_rise), .di_s(di_s),
        .wide(org_wide), .busy(busy), .rd_word(rd_word), .rd_idx(rd_idx),
        .prog_go(prog_go), .prog_kind(prog_kind), .prog_unit(prog_unit),
        .prog_data(prog_data), .wren(wren), .dout(dout), .dout_en(dout_en)
    );

    mw_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(prog_go), .busy(busy)
    );

    mw_array #(.MEM_AW(MEM_AW)) u_array (
        .clk(clk), .rst_n(rst_n), .go(prog_go), .kind(prog_kind),
        .wide(org_wide), .unit(prog_unit), .data(prog_data),
        .rd_idx(rd_idx), .rd_word(rd_word)
    );

endmodule

// File: rtl/mw_eeprom_checker.sv
// Temporal checks on the EEPROM model, attached to every instance by bind.
module mw_eeprom_checker (
    input logic clk,
    input logic rst_n,
    input logic cs_s,
    input logic sk_rise,
    input logic dout_en,
    input logic wren,
    input logic prog_go,
    input logic busy
);
    // Output released one clock after the synchronised select drops.
    p_release_on_deselect_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> !dout_en);

    // A programming cycle starts only with the latch set.
    p_locked_no_program_r4: assert property (@(posedge clk) disable iff (!rst_n)
        prog_go |-> wren);

    // No new programming cycle while one is running.
    p_no_start_while_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        prog_go |-> !busy);

    // Busy only ever begins right after a start request.
    p_busy_from_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(prog_go));

    // The latch only changes on a shift-clock edge.
    p_latch_on_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sk_rise |=> $stable(wren));
endmodule

bind mw_eeprom mw_eeprom_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sk_rise(sk_rise),
    .dout_en(dout_en), .wren(wren), .prog_go(prog_go), .busy(busy)
);

// File: tb/mw_eeprom_test.sv
module mw_eeprom_test;
    localparam int PROG = 120;
    localparam int H    = 5;

    logic clk = 1'b0, rst_n = 1'b0, org_wide = 1'b1;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic dout, dout_en;
    int   checks = 0, errors = 0, cyc = 0, cyc_rise = 0;
    logic [15:0] refm [64];

    mw_eeprom #(.FIELD_W(8), .MEM_AW(6), .PROG_CYCLES(PROG)) uut (
        .clk(clk), .rst_n(rst_n), .org_wide(org_wide), .cs(cs), .sk(sk),
        .di(di), .dout(dout), .dout_en(dout_en));

    always #5 clk = ~clk;
    always @(posedge clk) cyc++;

    task automatic tick(int n); repeat (n) @(negedge clk); endtask

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int fw(); return org_wide ? 7 : 8; endfunction
    function automatic int ww(); return org_wide ? 16 : 8; endfunction
    function automatic int subf(int s); return org_wide ? (s << 5) : (s << 6); endfunction
    function automatic int ref_unit(int u);
        if (org_wide) return int'(refm[u % 64]);
        if ((u % 128) % 2 == 1) return int'(refm[(u % 128) / 2][15:8]);
        return int'(refm[(u % 128) / 2][7:0]);
    endfunction

    task automatic put_bit(int b);
        di = b[0]; tick(H); sk = 1'b1; cyc_rise = cyc; tick(H); sk = 1'b0;
    endtask
    task automatic sel_on(); sk = 0; di = 0; cs = 1'b1; tick(H); endtask
    task automatic sel_off(); cs = 1'b0; di = 0; tick(2 * H); endtask
    task automatic send_field(int v, int n);
        for (int i = n - 1; i >= 0; i--) put_bit((v >> i) & 1);
    endtask
    task automatic issue(int opc, int field, bit has_data, int data);
        sel_on(); put_bit(1); send_field(opc, 2); send_field(field, fw());
        if (has_data) send_field(data, ww());
    endtask
    task automatic get_word(output int v);
        v = 0;
        for (int i = 0; i < ww(); i++) begin
            sk = 1'b1; tick(H); sk = 1'b0; tick(H); v = (v << 1) | int'(dout);
        end
    endtask

    // Ends the frame, re-selects at once and follows status until ready.
    task automatic wait_ready(string tag);
        int n = 0, lat;
        sel_off(); sel_on(); tick(H);
        chk({tag, " R9 busy shown"}, {dout_en, dout}, 2'b10);
        while (!(dout_en && dout) && n < 1000) begin tick(1); n++; end
        lat = cyc - cyc_rise;
        chk({tag, " R9 cycle length"}, (lat >= PROG && lat <= PROG + 12) ? 1 : 0, 1);
        sel_off();
    endtask

    task automatic read_check(string tag, int unit, int n);
        int v;
        issue(2, unit, 0, 0); tick(H);
        chk({tag, " R2 dummy"}, {dout_en, dout}, 2'b10);
        for (int k = 0; k < n; k++) begin
            get_word(v); chk(tag, v, ref_unit(unit + k));
        end
        sel_off();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog R9 actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int v;
        for (int i = 0; i < 64; i++) refm[i] = 16'hFFFF;
        tick(4); rst_n = 1'b1; tick(4);
        chk("R12 reset drive", dout_en, 0);
        read_check("R2 reset word", 0, 2);

        // R1: leading zeros before start bit, then read
        sel_on(); put_bit(0); put_bit(0); put_bit(1); send_field(2, 2); send_field(1, 7);
        tick(H); chk("R1 leading zeros dummy", {dout_en, dout}, 2'b10);
        get_word(v); chk("R1 leading zeros", v, 16'hFFFF); sel_off();

        // R4: latch clear, write and erase ignored
        issue(1, 3, 1, 16'h1234); sel_off(); sel_on(); tick(H);
        chk("R4 no busy after locked write", dout_en, 0); sel_off();
        read_check("R4 locked write", 3, 1);
        issue(0, subf(1), 1, 16'h0000); sel_off();
        read_check("R4 locked fill", 9, 1);

        // R5: set latch, R6 sweep of all words
        issue(0, subf(3), 0, 0); sel_off();
        for (int a = 0; a < 64; a++) begin
            logic [15:0] p = 16'(a * 16'h1357) ^ 16'hA5C3;
            issue(1, a, 1, int'(p)); refm[a] = p; wait_ready("R6 write");
        end
        // R3: stream all words plus wrap
        read_check("R3 stream", 0, 65);
        // R1: ignored top field bit
        read_check("R1 alias word", 7'h45, 1);

        // R10: re-select after completion
        issue(1, 12, 1, 16'h0F0F); refm[12] = 16'h0F0F;
        sel_off(); tick(PROG + 20); sel_on(); tick(H);
        chk("R10 no status after finish", dout_en, 0); sel_off();
        read_check("R6 late check", 12, 1);

        // R11: frame during busy/status ignored
        issue(1, 10, 1, 16'hBEEF); refm[10] = 16'hBEEF;
        sel_off(); sel_on(); tick(H);
        chk("R11 status busy", {dout_en, dout}, 2'b10);
        put_bit(1); send_field(1, 2); send_field(10, 7); send_field(16'h1111, 16);
        tick(H); chk("R11 status ready", {dout_en, dout}, 2'b11);
        sel_off(); read_check("R11 ignored frame", 10, 1);

        // R7: erase word
        issue(3, 7, 0, 0); refm[7] = 16'hFFFF; wait_ready("R7 erase");
        read_check("R7 erase word", 6, 3);

        // byte mode
        org_wide = 1'b0; tick(2);
        read_check("R2 byte stream", 8, 6);
        read_check("R3 byte wrap", 126, 4);
        read_check("R1 alias byte", 8'h89, 1);
        issue(1, 9, 1, 8'h5A); refm[4][15:8] = 8'h5A; wait_ready("R6 byte write");
        issue(3, 10, 0, 0); refm[5][7:0] = 8'hFF; wait_ready("R7 byte erase");
        org_wide = 1'b1; tick(2);
        read_check("R6 byte into word", 4, 2);

        // R5: lock, erase ignored, read still works
        issue(0, subf(0), 0, 0); sel_off();
        issue(3, 8, 0, 0); sel_off(); sel_on(); tick(H);
        chk("R5 locked erase no busy", dout_en, 0); sel_off();
        read_check("R5 read while locked", 8, 1);

        // R8: fill word mode, then byte mode; R7 whole erase
        issue(0, subf(3), 0, 0); sel_off();
        issue(0, subf(1), 1, 16'hC3A5);
        for (int i = 0; i < 64; i++) refm[i] = 16'hC3A5;
        wait_ready("R8 fill");
        read_check("R8 fill word", 0, 64);
        org_wide = 1'b0; tick(2);
        issue(0, subf(1), 1, 8'h3C);
        for (int i = 0; i < 64; i++) refm[i] = 16'h3C3C;
        wait_ready("R8 fill byte");
        org_wide = 1'b1; tick(2);
        read_check("R8 byte fill", 20, 4);
        issue(0, subf(2), 0, 0);
        for (int i = 0; i < 64; i++) refm[i] = 16'hFFFF;
        wait_ready("R7 whole erase");
        read_check("R7 whole erase", 0, 64);
        chk("R12 idle drive", dout_en, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule